// File: doc/BRIEF.md
# Mode-Switching Branch Linkage Unit

This unit sits beside the branch logic of a processor that runs in two addressing modes: a narrow mode, where only the low 24 bits of a 32-bit word form an address, and a wide mode, where only the most significant bit is dropped and the low 31 bits form the address. On each valid strobe it takes a decoded call or return opcode, the target operand, the two register numbers, the updated instruction address and the current condition code and program mask. From these it computes the word to write into the link register, whether a branch is taken, the masked target address and the addressing mode that follows.

The link word records either status (in the narrow mode of the status-carrying call) or the caller's mode in its top bit. The top bit of a mode-setting target selects the callee's mode. Calls and returns can therefore pass between narrow and wide code in any of the four pairings. The unit holds the addressing-mode flag itself. It also offers a combinational masker that turns any effective address into an address in the current mode.

Top module: `mode_link_unit`

## Requirements
- R1: After reset the mode is narrow (`modeBit`=0) and `linkWe` and `branchTaken` are 0.
- R2: `eaOut` equals `eaIn` with its top 8 bits cleared while `modeBit`=0. It equals `eaIn` with bit 31 cleared while `modeBit`=1.
- R3: Opcode 0 (status call) in narrow mode writes a link word with bits 31:30 = length code (00 when `opImmForm`=0, 01 when `opImmForm`=1), bits 29:28 = `condCode`, bits 27:24 = `progMask`, and bits 23:0 = `nextAddr[23:0]`. The mode is unchanged.
- R4: Opcode 0 in wide mode writes a link word with bit 31 set and bits 30:0 = `nextAddr[30:0]`, with no status.
- R5: Opcode 1 (plain store call) writes `nextAddr[23:0]` with zero upper bits in narrow mode. In wide mode it writes `nextAddr[30:0]` with bit 31 clear. The mode is unchanged.
- R6: Opcode 2 (save-and-switch) writes a link word whose bit 31 is the mode in force before the call. The low bits are `nextAddr[23:0]` with zeros above in narrow mode, or `nextAddr[30:0]` in wide mode. It branches to `opndB`, and the new mode is `opndB[31]`.
- R7: Opcode 3 (switch) branches to `opndB` in the mode given by `opndB[31]`. The link register is written, in the R6 format, only when `regNumA` is nonzero.
- R8: For a register-only form (opcode 2 or 3, or opcode 0/1 with `opImmForm`=0) with `regNumB`=0, no branch is taken and the mode is unchanged. The link register is still written when R3 to R7 call for it.
- R9: Results appear at the clock edge that samples `opValid`=1. `linkWe` and `branchTaken` are high for that one cycle only. With `opValid`=0 the mode does not change.
- R10: `targetAddr` is `opndB` masked for the mode after the branch: the current mode for opcodes 0 and 1, `opndB[31]` for opcodes 2 and 3. Immediate forms of opcodes 0 and 1 always branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Opcode strobe |
| opCode | input | 2 | 0 status call, 1 plain store call, 2 save-and-switch, 3 switch |
| opImmForm | input | 1 | 1 selects the register-immediate form of opcodes 0 and 1 |
| regNumA | input | 4 | Link register number |
| regNumB | input | 4 | Target register number (0 means no branch for register forms) |
| opndB | input | 32 | Target operand word |
| nextAddr | input | 32 | Updated instruction address (return point) |
| condCode | input | 2 | Current condition code |
| progMask | input | 4 | Current program mask |
| eaIn | input | 32 | Effective address to mask |
| linkWe | output | 1 | Link register write enable |
| linkData | output | 32 | Link register write value |
| branchTaken | output | 1 | Branch taken |
| targetAddr | output | 32 | Masked branch target |
| modeBit | output | 1 | Current addressing mode (1 = wide) |
| eaOut | output | 32 | `eaIn` masked for the current mode |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 24-bit narrow address and 4-bit register numbers. With these values the 8-bit status byte layout and both mask widths can be observed directly. A single sequence of vectors carries the mode across operations, so narrow-to-wide, wide-to-narrow, narrow-to-narrow and wide-to-wide calls are each paired with their returns. Directed steps then cover reset, idle strobes and the masker in both modes.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

  typedef enum logic [1:0] {
    OP_LINK_STAT  = 2'd0,
    OP_LINK_STORE = 2'd1,
    OP_SAVE_SET   = 2'd2,
    OP_SET_MODE   = 2'd3
  } brOp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic linkWrite;
    logic branch;
    logic modeFromTarget;
    logic statusForm;
    logic storeForm;
    logic ilcLow;
  } strobes_t;

endpackage

// File: rtl/mlu_ctrl.sv
module mlu_ctrl
  import mlu_pkg::*;
#(
  parameter int REGNUM_W = 4
) (
  input  logic [1:0]          opCode,
  input  logic                opImmForm,
  input  logic [REGNUM_W-1:0] regNumA,
  input  logic [REGNUM_W-1:0] regNumB,
  output strobes_t            strb
);

  brOp_t op;
  logic  regForm;

  assign op = brOp_t'(opCode);

  always_comb begin
    regForm = 1'b1;
    if (op == OP_LINK_STAT || op == OP_LINK_STORE) regForm = !opImmForm;

    strb                = '0;
    strb.branch         = !(regForm && (regNumB == '0));
    strb.linkWrite      = (op != OP_SET_MODE) || (regNumA != '0);
    strb.modeFromTarget = (op == OP_SAVE_SET) || (op == OP_SET_MODE);
    strb.statusForm     = (op == OP_LINK_STAT);
    strb.storeForm      = (op == OP_LINK_STORE);
    strb.ilcLow         = !regForm;
  end

endmodule

// File: rtl/mlu_datapath.sv
module mlu_datapath
  import mlu_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 24,
  parameter int CC_W     = 2,
  parameter int PM_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] opndB,
  input  logic [WORD_W-1:0] nextAddr,
  input  logic [CC_W-1:0]   condCode,
  input  logic [PM_W-1:0]   progMask,
  input  logic [WORD_W-1:0] eaIn,
  output logic              linkWe,
  output logic [WORD_W-1:0] linkData,
  output logic              branchTaken,
  output logic [WORD_W-1:0] targetAddr,
  output logic              modeBit,
  output logic [WORD_W-1:0] eaOut
);

  localparam int WIDE_W = WORD_W - 1;
  localparam int STAT_W = WORD_W - NARROW_W;
  localparam int ILC_W  = STAT_W - CC_W - PM_W;

  logic              modeQ;
  logic              newMode;
  logic [WORD_W-1:0] tgtMasked;
  logic [WORD_W-1:0] linkWord;
  logic [WORD_W-1:0] narrowRet;
  logic [WORD_W-1:0] wideRet;
  logic [ILC_W-1:0]  ilc;
  logic              unusedTop;

  function automatic logic [WORD_W-1:0] maskAddr(input logic wide, input logic [WORD_W-1:0] w);
    if (wide) return {1'b0, w[WIDE_W-1:0]};
    return {{STAT_W{1'b0}}, w[NARROW_W-1:0]};
  endfunction

  assign unusedTop = nextAddr[WORD_W-1] ^ eaIn[WORD_W-1];
  assign ilc       = {{(ILC_W-1){1'b0}}, strb.ilcLow};
  assign narrowRet = {{STAT_W{1'b0}}, nextAddr[NARROW_W-1:0]};
  assign wideRet   = {1'b1, nextAddr[WIDE_W-1:0]};
  assign newMode   = strb.modeFromTarget ? opndB[WORD_W-1] : modeQ;
  assign tgtMasked = maskAddr(newMode, opndB);
  assign eaOut     = maskAddr(modeQ, eaIn);

  always_comb begin
    if (modeQ) linkWord = strb.storeForm ? {1'b0, nextAddr[WIDE_W-1:0]} : wideRet;
    else if (strb.statusForm) linkWord = {ilc, condCode, progMask, nextAddr[NARROW_W-1:0]};
    else linkWord = narrowRet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ       <= 1'b0;
      linkWe      <= 1'b0;
      branchTaken <= 1'b0;
      linkData    <= '0;
      targetAddr  <= '0;
    end else begin
      linkWe      <= opValid && strb.linkWrite;
      branchTaken <= opValid && strb.branch;
      if (opValid) linkData <= linkWord;
      if (opValid && strb.branch) begin
        targetAddr <= tgtMasked;
        modeQ      <= newMode;
      end
    end
  end

  assign modeBit = modeQ;

  // R9
  link_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkWe || branchTaken) |-> $past(opValid));

  // R8
  mode_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != $past(modeQ)) |-> $past(opValid && strb.modeFromTarget && strb.branch));

  // R10
  narrow_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken && !modeQ) |-> (targetAddr[WORD_W-1:NARROW_W] == '0));

  // R10
  wide_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (branchTaken && modeQ) |-> !targetAddr[WORD_W-1]);

endmodule

// File: rtl/mode_link_unit.sv
module mode_link_unit
  import mlu_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 24,
  parameter int REGNUM_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [1:0]          opCode,
  input  logic                opImmForm,
  input  logic [REGNUM_W-1:0] regNumA,
  input  logic [REGNUM_W-1:0] regNumB,
  input  logic [WORD_W-1:0]   opndB,
  input  logic [WORD_W-1:0]   nextAddr,
  input  logic [1:0]          condCode,
  input  logic [3:0]          progMask,
  input  logic [WORD_W-1:0]   eaIn,
  output logic                linkWe,
  output logic [WORD_W-1:0]   linkData,
  output logic                branchTaken,
  output logic [WORD_W-1:0]   targetAddr,
  output logic                modeBit,
  output logic [WORD_W-1:0]   eaOut
);

  strobes_t strb;

  mlu_ctrl #(.REGNUM_W(REGNUM_W)) uCtrl (
    .opCode   (opCode),
    .opImmForm(opImmForm),
    .regNumA  (regNumA),
    .regNumB  (regNumB),
    .strb     (strb)
  );

  mlu_datapath #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .CC_W(2), .PM_W(4)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .strb       (strb),
    .opndB      (opndB),
    .nextAddr   (nextAddr),
    .condCode   (condCode),
    .progMask   (progMask),
    .eaIn       (eaIn),
    .linkWe     (linkWe),
    .linkData   (linkData),
    .branchTaken(branchTaken),
    .targetAddr (targetAddr),
    .modeBit    (modeBit),
    .eaOut      (eaOut)
  );

  // R7
  switch_nosave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'd3 && regNumA == '0) |=> !linkWe);

  // R2
  ea_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeBit ? !eaOut[WORD_W-1] : (eaOut[WORD_W-1:NARROW_W] == '0));

endmodule

// File: tb/tb_mode_link_unit.sv
module tb_mode_link_unit;

  typedef struct packed {
    logic [1:0]  op;
    logic        imm;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] b;
    logic [31:0] nxt;
    logic        we;
    logic [31:0] link;
    logic        tk;
    logic [31:0] tgt;
    logic        md;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 4'd14, 4'd15, 32'hAB12_3456, 32'h7F12_3404, 1'b1, 32'h2512_3404, 1'b1, 32'h0012_3456, 1'b0}, // R3 reg form
    '{2'd0, 1'b1, 4'd14, 4'd0,  32'h0000_2000, 32'h0000_5006, 1'b1, 32'h6500_5006, 1'b1, 32'h0000_2000, 1'b0}, // R3 imm, R10
    '{2'd2, 1'b0, 4'd14, 4'd15, 32'h8123_4568, 32'h0040_0102, 1'b1, 32'h0040_0102, 1'b1, 32'h0123_4568, 1'b1}, // R6 narrow->wide
    '{2'd0, 1'b0, 4'd14, 4'd3,  32'hFFFF_FFF0, 32'h0123_4570, 1'b1, 32'h8123_4570, 1'b1, 32'h7FFF_FFF0, 1'b1}, // R4
    '{2'd1, 1'b0, 4'd14, 4'd5,  32'h8000_0100, 32'hC765_4322, 1'b1, 32'h4765_4322, 1'b1, 32'h0000_0100, 1'b1}, // R5 wide
    '{2'd3, 1'b0, 4'd0,  4'd14, 32'h0040_0102, 32'h0000_0000, 1'b0, 32'h0,         1'b1, 32'h0040_0102, 1'b0}, // R7 ret wide->narrow
    '{2'd1, 1'b1, 4'd14, 4'd0,  32'h1200_0400, 32'hFF00_0AB4, 1'b1, 32'h0000_0AB4, 1'b1, 32'h0000_0400, 1'b0}, // R5 narrow
    '{2'd2, 1'b0, 4'd14, 4'd15, 32'h0050_0000, 32'h0000_0C00, 1'b1, 32'h0000_0C00, 1'b1, 32'h0050_0000, 1'b0}, // R6 narrow->narrow
    '{2'd3, 1'b0, 4'd0,  4'd14, 32'h0000_0C00, 32'h0000_0000, 1'b0, 32'h0,         1'b1, 32'h0000_0C00, 1'b0}, // R7
    '{2'd2, 1'b0, 4'd14, 4'd15, 32'h8000_8000, 32'h0000_0C10, 1'b1, 32'h0000_0C10, 1'b1, 32'h0000_8000, 1'b1}, // R6
    '{2'd2, 1'b0, 4'd14, 4'd15, 32'h8765_0000, 32'h8000_9002, 1'b1, 32'h8000_9002, 1'b1, 32'h0765_0000, 1'b1}, // R6 wide->wide
    '{2'd3, 1'b0, 4'd0,  4'd14, 32'h8000_9002, 32'h0000_0000, 1'b0, 32'h0,         1'b1, 32'h0000_9002, 1'b1}, // R7
    '{2'd2, 1'b0, 4'd14, 4'd15, 32'h0006_0000, 32'h8012_3456, 1'b1, 32'h8012_3456, 1'b1, 32'h0006_0000, 1'b0}, // R6 wide->narrow
    '{2'd3, 1'b0, 4'd0,  4'd14, 32'h8012_3456, 32'h0000_0000, 1'b0, 32'h0,         1'b1, 32'h0012_3456, 1'b1}, // R7 ret narrow->wide
    '{2'd3, 1'b0, 4'd7,  4'd0,  32'h0000_0000, 32'h0000_0200, 1'b1, 32'h8000_0200, 1'b0, 32'h0,         1'b1}, // R8 R7
    '{2'd2, 1'b0, 4'd14, 4'd0,  32'h0000_1000, 32'h0000_0300, 1'b1, 32'h8000_0300, 1'b0, 32'h0,         1'b1}, // R8
    '{2'd0, 1'b0, 4'd14, 4'd0,  32'h0000_1000, 32'h0000_0400, 1'b1, 32'h8000_0400, 1'b0, 32'h0,         1'b1}, // R8
    '{2'd3, 1'b0, 4'd2,  4'd9,  32'h00AB_CDEF, 32'h0000_0500, 1'b1, 32'h8000_0500, 1'b1, 32'h00AB_CDEF, 1'b0}  // R7 saved
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = '0;
  logic        opImmForm = 1'b0;
  logic [3:0]  regNumA = '0, regNumB = '0;
  logic [31:0] opndB = '0, nextAddr = '0, eaIn = '0;
  logic [1:0]  condCode = 2'b10;
  logic [3:0]  progMask = 4'b0101;
  logic        linkWe, branchTaken, modeBit;
  logic [31:0] linkData, targetAddr, eaOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mode_link_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opImmForm(opImmForm),
    .regNumA(regNumA), .regNumB(regNumB), .opndB(opndB), .nextAddr(nextAddr),
    .condCode(condCode), .progMask(progMask), .eaIn(eaIn), .linkWe(linkWe),
    .linkData(linkData), .branchTaken(branchTaken), .targetAddr(targetAddr),
    .modeBit(modeBit), .eaOut(eaOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic imm, input logic [3:0] ra,
                       input logic [3:0] rb, input logic [31:0] b, input logic [31:0] nxt);
    opCode = op; opImmForm = imm; regNumA = ra; regNumB = rb; opndB = b; nextAddr = nxt;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 mode", {31'b0, modeBit}, 32'd0);
    check("R1 linkWe", {31'b0, linkWe}, 32'd0);
    check("R1 branchTaken", {31'b0, branchTaken}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].imm, VECS[i].ra, VECS[i].rb, VECS[i].b, VECS[i].nxt);
      check($sformatf("vec%0d linkWe R3-R8", i), {31'b0, linkWe}, {31'b0, VECS[i].we});
      check($sformatf("vec%0d taken R8 R10", i), {31'b0, branchTaken}, {31'b0, VECS[i].tk});
      check($sformatf("vec%0d mode R6 R7", i), {31'b0, modeBit}, {31'b0, VECS[i].md});
      if (VECS[i].we) check($sformatf("vec%0d link word R3 R4 R5 R6", i), linkData, VECS[i].link);
      if (VECS[i].tk) check($sformatf("vec%0d target R10", i), targetAddr, VECS[i].tgt);
    end

    // R2 narrow masker (mode is narrow after the table)
    eaIn = 32'hFFFF_FFFF; #1;
    check("R2 narrow mask", eaOut, 32'h00FF_FFFF);

    // R9 one-cycle pulses, strobe low ignores inputs
    @(negedge clk);
    check("R9 linkWe drops", {31'b0, linkWe}, 32'd0);
    check("R9 taken drops", {31'b0, branchTaken}, 32'd0);
    opCode = 2'd3; regNumA = 4'd5; regNumB = 4'd6; opndB = 32'h8000_4000;
    @(negedge clk);
    check("R9 idle mode held", {31'b0, modeBit}, 32'd0);
    check("R9 idle no write", {31'b0, linkWe}, 32'd0);
    check("R9 idle no branch", {31'b0, branchTaken}, 32'd0);

    // R2 wide masker
    drive(2'd3, 1'b0, 4'd0, 4'd1, 32'h8000_0000, 32'h0);
    check("R2 entered wide", {31'b0, modeBit}, 32'd1);
    eaIn = 32'hFFFF_FFFF; #1;
    check("R2 wide mask", eaOut, 32'h7FFF_FFFF);
    eaIn = 32'h1234_5678; #1;
    check("R2 wide mask pattern", eaOut, 32'h1234_5678);

    // R1 reset returns to narrow mode
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset mode", {31'b0, modeBit}, 32'd0);
    check("R1 reset linkWe", {31'b0, linkWe}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule